// File: doc/BRIEF.md
# Multi-Lane Serial Flash Byte Shifter

This block is the bit-level engine under a serial flash controller. The controller hands it one command at a time through a valid/ready handshake. Each command carries a half-period divider, a three-bit mode and a clock-count field. The engine then toggles the serial clock, drives one, two or four data lanes, or samples them, and finishes with the clock parked low. A command either moves a whole byte or gives a shorter run of clocks, which the controller uses for dummy cycles.

Bits travel most-significant first. Outputs move on the falling clock edge and inputs are captured on the rising edge, with the clock idling low. Received bytes come back with their own one-cycle acknowledge. This acknowledge arrives well after the command was accepted, so the controller can queue the next command while a read is still finishing. The engine reports when it has nothing left to shift. It also reopens its handshake in the cycle of the final falling edge, so that a waiting command continues the clock with no gap.

Top module: `spi_lane_shifter`

## Requirements
- R1: The serial clock stays low while no command is active. During a command, every high phase and every low phase lasts exactly (div+1) system clocks, where div is the 8-bit divider taken with that command. The first rising edge comes (div+1) cycles after acceptance.
- R2: mode[2:1] selects lane usage. 2'b10 is dual: two bits per clock on lanes 1:0, lane 1 carrying the more significant bit. 2'b11 is quad: four bits per clock on lanes 3:0, lane 3 most significant. Every other code is single: one bit per clock. A width the built lane count cannot carry falls back to single. Data goes out MSB first.
- R3: During a command, the output enables are as follows. Single mode enables lane 0 only, in both directions. Dual or quad transmit enables exactly the lanes in use. Dual or quad receive enables none. All enables are low when idle.
- R4: A command produces exactly clks+1 rising edges of the serial clock, where clks is its 3-bit count field.
- R5: A command is taken on a rising clock edge where cmd_valid and cmd_ready are both high. The transmit byte is captured at that edge, and later changes to cmd_txd do not alter the bits sent.
- R6: mode[0]=1 means transmit and mode[0]=0 means receive. A receive command raises rx_ack for exactly one cycle, starting at the edge of its last rising serial-clock edge. rx_data then holds the last eight sampled bits, with the latest in the least significant positions and zeros above when fewer than eight bits were sampled. A transmit command never raises rx_ack.
- R7: bus_idle is low from acceptance until the final falling edge. It rises exactly 2*(clks+1)*(div+1) cycles after acceptance, and cmd_ready is high whenever bus_idle is high.
- R8: While busy, cmd_ready is high only in the cycle whose edge makes the final falling edge. A command accepted there starts its first low phase at once, with no extra gap.
- R9: After a synchronous active-low reset, even one applied mid-command, sck is low, all output enables are low, cmd_ready and bus_idle are high and rx_ack is low.
- R10: In single mode the outgoing bit is on lane 0. The incoming bit is read from lane 1 when two or more lanes are built, and from lane 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command this cycle |
| cmd_div | input | DIV_W | Half-period divider minus one |
| cmd_mode | input | 3 | Lane width (bits 2:1) and direction (bit 0) |
| cmd_clks | input | CNT_W | Serial clock pulses minus one |
| cmd_txd | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last received byte |
| rx_ack | output | 1 | One-cycle strobe marking rx_data valid |
| bus_idle | output | 1 | No command in progress |
| sck | output | 1 | Serial clock |
| sd_out | output | LANES | Per-lane data out |
| sd_oe | output | LANES | Per-lane output enable |
| sd_in | input | LANES | Per-lane data in |

## Verification
The hardest situation to reach is a second command landing in the single cycle where the first one makes its final falling edge. That is the only point at which busy-time acceptance is legal and the clock must continue without a gap. The stimulus raises the second command as soon as the last rising edge of the first has been seen, and then holds it until the handshake opens. It then checks the acceptance cycle against that rising edge. A reset dropped in the middle of a long command covers the other state that is hard to reach. Seeded random commands vary divider, lane width, direction and pulse count, while the bench acts as the flash and drives fresh random lane values in every low phase.

// File: rtl/sls_pkg.sv
// Shared types for the lane shifter: lane-width encoding and decode helpers.
// Assumes the lane count is one of 1, 2 or 4.
package sls_pkg;

    typedef enum logic [1:0] {
        LW_SINGLE = 2'd0,
        LW_DUAL   = 2'd1,
        LW_QUAD   = 2'd2
    } lane_width_e;

    // Map mode bits 2:1 to a width, falling back to single when lanes are missing.
    function automatic lane_width_e decode_width(input logic [2:0] mode, input int lanes);
        if (mode[2:1] == 2'b11 && lanes >= 4) return LW_QUAD;
        if (mode[2:1] == 2'b10 && lanes >= 2) return LW_DUAL;
        return LW_SINGLE;
    endfunction

    // Bits moved per serial clock for a width.
    function automatic int bits_per_clk(input lane_width_e w);
        case (w)
            LW_DUAL: return 2;
            LW_QUAD: return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sls_sck_gen.sv
// Serial clock generator. Counts (half_div+1) system clocks per phase while
// run is high and reports the edge about to happen as rise_evt / fall_evt.
// Assumes half_div only changes together with restart.
module sls_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] hcnt;
    logic             tick;

    assign tick     = run && (hcnt == half_div);
    assign rise_evt = tick && !sck;
    assign fall_evt = tick && sck;

    // Phase counter and clock toggle; restart begins a fresh low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            sck  <= 1'b0;
        end else if (restart) begin
            hcnt <= '0;
            sck  <= 1'b0;
        end else if (tick) begin
            hcnt <= '0;
            sck  <= ~sck;
        end else if (run) begin
            hcnt <= hcnt + 1'b1;
        end else begin
            hcnt <= '0;
            sck  <= 1'b0;
        end
    end

    assert_sck_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !restart) |=> $stable(sck));

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |=> (hcnt <= half_div));

endmodule

// File: rtl/sls_tx_path.sv
// Transmit shifter. Captures a byte on load and moves it out MSB first,
// one, two or four bits per shift, onto the lane outputs.
// Assumes LANES is 1, 2 or 4.
module sls_tx_path
    import sls_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       load_byte,
    input  logic             shift,
    input  lane_width_e      width,
    output logic [LANES-1:0] lane_out
);

    logic [7:0] shreg;
    logic [3:0] out4;

    // Byte capture on acceptance, width-dependent left shift on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= load_byte;
        end else if (shift) begin
            case (width)
                LW_DUAL: shreg <= {shreg[5:0], 2'b00};
                LW_QUAD: shreg <= {shreg[3:0], 4'b0000};
                default: shreg <= {shreg[6:0], 1'b0};
            endcase
        end
    end

    // Present the leading bits on the lanes the width uses.
    always_comb begin
        case (width)
            LW_DUAL: out4 = {2'b00, shreg[7:6]};
            LW_QUAD: out4 = shreg[7:4];
            default: out4 = {3'b000, shreg[7]};
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane_out
        assign lane_out[i] = out4[i];
    end

endmodule

// File: rtl/sls_rx_path.sv
// Receive assembler. Samples the lanes on rising edges into a byte shifter
// and latches the result with a one-cycle acknowledge at the final sample.
// Assumes LANES is 1, 2 or 4; single mode reads lane 1 when it exists.
module sls_rx_path
    import sls_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             finish,
    input  lane_width_e      width,
    input  logic [LANES-1:0] lane_in,
    output logic [7:0]       rx_byte,
    output logic             rx_ack
);

    localparam int MISO_IDX = (LANES > 1) ? 1 : 0;

    logic [3:0] in4;
    logic [7:0] shreg;
    logic [7:0] nxt;

    for (genvar j = 0; j < 4; j++) begin : g_in4
        if (j < LANES) begin : g_have
            assign in4[j] = lane_in[j];
        end else begin : g_none
            assign in4[j] = 1'b0;
        end
    end

    // Next shifter value with the newest bits entering at the bottom.
    always_comb begin
        case (width)
            LW_DUAL: nxt = {shreg[5:0], in4[1:0]};
            LW_QUAD: nxt = {shreg[3:0], in4[3:0]};
            default: nxt = {shreg[6:0], in4[MISO_IDX]};
        endcase
    end

    // Shifter, result latch and acknowledge strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            rx_byte <= '0;
            rx_ack  <= 1'b0;
        end else begin
            rx_ack <= finish;
            if (clear) begin
                shreg <= '0;
            end else if (sample) begin
                shreg <= nxt;
            end
            if (finish) begin
                rx_byte <= nxt;
            end
        end
    end

    assert_ack_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> !rx_ack);

endmodule

// File: rtl/spi_lane_shifter.sv
// Multi-lane serial byte engine. Accepts one command per handshake, runs
// clks+1 serial clock pulses at the command's divider over 1, 2 or 4 lanes,
// and acknowledges received bytes separately from acceptance.
// Assumes the controller holds chip select; LANES is 1, 2 or 4.
module spi_lane_shifter
    import sls_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DIV_W = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [DIV_W-1:0] cmd_div,
    input  logic [2:0]       cmd_mode,
    input  logic [CNT_W-1:0] cmd_clks,
    input  logic [7:0]       cmd_txd,
    output logic [7:0]       rx_data,
    output logic             rx_ack,
    output logic             bus_idle,
    output logic             sck,
    output logic [LANES-1:0] sd_out,
    output logic [LANES-1:0] sd_oe,
    input  logic [LANES-1:0] sd_in
);

    logic             busy;
    logic [CNT_W-1:0] left;
    lane_width_e      width_q;
    logic             tx_q;
    logic [DIV_W-1:0] div_q;
    logic             rise_evt;
    logic             fall_evt;
    logic             last;
    logic             accept;

    assign last      = (left == '0);
    assign cmd_ready = !busy || (fall_evt && last);
    assign accept    = cmd_valid && cmd_ready;
    assign bus_idle  = !busy;

    // Command register and pulse countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            left    <= '0;
            width_q <= LW_SINGLE;
            tx_q    <= 1'b0;
            div_q   <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            left    <= cmd_clks;
            width_q <= decode_width(cmd_mode, LANES);
            tx_q    <= cmd_mode[0];
            div_q   <= cmd_div;
        end else if (fall_evt) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    sls_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .restart  (accept),
        .half_div (div_q),
        .sck      (sck),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    sls_tx_path #(.LANES(LANES)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_byte (cmd_txd),
        .shift     (fall_evt && !last),
        .width     (width_q),
        .lane_out  (sd_out)
    );

    sls_rx_path #(.LANES(LANES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .sample  (rise_evt),
        .finish  (rise_evt && last && !tx_q),
        .width   (width_q),
        .lane_in (sd_in),
        .rx_byte (rx_data),
        .rx_ack  (rx_ack)
    );

    // Per-lane output enable from width and direction.
    for (genvar i = 0; i < LANES; i++) begin : g_oe
        if (i == 0) begin : g_lane0
            assign sd_oe[i] = busy && ((width_q == LW_SINGLE) || tx_q);
        end else begin : g_laneN
            assign sd_oe[i] = busy && tx_q && (width_q != LW_SINGLE) &&
                              (i < bits_per_clk(width_q));
        end
    end

    assert_sck_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    assert_oe_off_wide_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_q && width_q != LW_SINGLE) |-> (sd_oe == '0));

    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);

    assert_ack_in_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> (busy && !tx_q));

    assert_idle_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> cmd_ready);

    assert_ready_at_last_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_ready) |-> (sck && last));

endmodule

// File: tb/sim_spi_lane_shifter.sv
module sim_spi_lane_shifter;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int DIV_W = 8;
    localparam int CNT_W = 3;

    logic             clk;
    logic             rst_n;
    logic             cmd_valid;
    logic             cmd_ready;
    logic [DIV_W-1:0] cmd_div;
    logic [2:0]       cmd_mode;
    logic [CNT_W-1:0] cmd_clks;
    logic [7:0]       cmd_txd;
    logic [7:0]       rx_data;
    logic             rx_ack;
    logic             bus_idle;
    logic             sck;
    logic [LANES-1:0] sd_out;
    logic [LANES-1:0] sd_oe;
    logic [LANES-1:0] sd_in;

    spi_lane_shifter #(.LANES(LANES), .DIV_W(DIV_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_div(cmd_div), .cmd_mode(cmd_mode), .cmd_clks(cmd_clks), .cmd_txd(cmd_txd),
        .rx_data(rx_data), .rx_ack(rx_ack), .bus_idle(bus_idle), .sck(sck),
        .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model state
    bit          mon_en = 0;
    logic        sck_prev = 1'b0;
    int          last_tog = 0;
    int          acc_edge = 0;
    int          exp_div = 0;
    int          exp_w = 0;
    bit          exp_tx = 0;
    int          exp_p = 0;
    logic [7:0]  exp_byte = '0;
    int          rise_cnt = 0;
    logic [31:0] rx_acc = '0;
    logic [31:0] tx_acc = '0;
    int          ack_cnt = 0;
    int          ack_cyc = 0;
    logic [7:0]  ack_dat = '0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int w_of(input logic [2:0] mode);
        if (mode[2:1] == 2'b11) return 2;
        if (mode[2:1] == 2'b10) return 1;
        return 0;
    endfunction

    function automatic logic [3:0] pick_in(input logic [3:0] v, input int w);
        if (w == 2) return v;
        if (w == 1) return {2'b00, v[1:0]};
        return {3'b000, v[1]};
    endfunction

    function automatic logic [3:0] pick_out(input logic [3:0] v, input int w);
        if (w == 2) return v;
        if (w == 1) return {2'b00, v[1:0]};
        return {3'b000, v[0]};
    endfunction

    function automatic logic [3:0] exp_oe(input int w, input bit tx);
        if (w == 0) return 4'b0001;
        if (!tx) return 4'b0000;
        return (w == 2) ? 4'b1111 : 4'b0011;
    endfunction

    function automatic logic [31:0] exp_tx_bits(input logic [7:0] b, input int total);
        logic [31:0] full;
        full = {b, 24'h0};
        return full >> (32 - total);
    endfunction

    // One system clock: observe away from the edge, then act as the flash.
    task automatic step();
        int k;
        @(negedge clk);
        k = 1 << exp_w;
        if (mon_en) begin
            if (sck !== sck_prev) begin
                check(cyc - last_tog == exp_div + 1, "R1 phase length", cyc - last_tog, exp_div + 1);
                last_tog = cyc;
                if (sck) begin
                    rise_cnt++;
                    rx_acc = (rx_acc << k) | 32'(pick_in(sd_in, exp_w));
                    tx_acc = (tx_acc << k) | 32'(pick_out(sd_out, exp_w));
                    check(sd_oe == exp_oe(exp_w, exp_tx), "R3 output enables", sd_oe, exp_oe(exp_w, exp_tx));
                end
            end
            if (rx_ack) begin
                ack_cnt++;
                ack_cyc = cyc;
                ack_dat = rx_data;
            end
        end
        sck_prev = sck;
        if (!sck) sd_in = 4'($urandom);
    endtask

    task automatic start_cmd(input int div, input logic [2:0] mode, input int clks, input logic [7:0] b);
        cmd_div   = DIV_W'(div);
        cmd_mode  = mode;
        cmd_clks  = CNT_W'(clks);
        cmd_txd   = b;
        cmd_valid = 1'b1;
        while (!cmd_ready) step();
        acc_edge = cyc + 1;
        exp_div  = div;
        exp_w    = w_of(mode);
        exp_tx   = mode[0];
        exp_p    = clks + 1;
        exp_byte = b;
        rise_cnt = 0;
        rx_acc   = '0;
        tx_acc   = '0;
        ack_cnt  = 0;
        step();
        last_tog  = acc_edge;
        cmd_valid = 1'b0;
        cmd_txd   = 8'($urandom);  // R5: later changes must not reach the lanes
    endtask

    task automatic finish_cmd();
        int guard = 0;
        int k;
        k = 1 << exp_w;
        while (!bus_idle && guard < 5000) begin
            step();
            guard++;
        end
        check(cyc - acc_edge == 2 * exp_p * (exp_div + 1), "R7 idle timing", cyc - acc_edge, 2 * exp_p * (exp_div + 1));
        check(cmd_ready == 1'b1, "R7 ready when idle", cmd_ready, 1);
        check(sck == 1'b0 && sd_oe == '0, "R1 idle clock and enables", {sck, sd_oe}, 0);
        check(rise_cnt == exp_p, "R4 pulse count", rise_cnt, exp_p);
        if (exp_tx || exp_w == 0)
            check(tx_acc == exp_tx_bits(exp_byte, exp_p * k), "R2 R5 R10 transmitted bits", tx_acc, exp_tx_bits(exp_byte, exp_p * k));
        if (exp_tx) begin
            check(ack_cnt == 0, "R6 no ack on transmit", ack_cnt, 0);
        end else begin
            check(ack_cnt == 1, "R6 single ack", ack_cnt, 1);
            check(ack_cyc - acc_edge == (2 * exp_p - 1) * (exp_div + 1), "R6 ack timing", ack_cyc - acc_edge, (2 * exp_p - 1) * (exp_div + 1));
            check(ack_dat == rx_acc[7:0], "R6 R10 received byte", ack_dat, rx_acc[7:0]);
        end
    endtask

    task automatic run_cmd(input int div, input logic [2:0] mode, input int clks, input logic [7:0] b);
        start_cmd(div, mode, clks, b);
        finish_cmd();
    endtask

    task automatic check_reset_state(input string tag);
        check(sck == 1'b0, tag, sck, 0);
        check(sd_oe == '0, tag, sd_oe, 0);
        check(cmd_ready && bus_idle && !rx_ack, tag, {cmd_ready, bus_idle, rx_ack}, 3'b110);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_div = '0;
        cmd_mode = '0;
        cmd_clks = '0;
        cmd_txd = '0;
        sd_in = '0;
        repeat (3) step();
        check_reset_state("R9 reset state");
        rst_n = 1'b1;
        step();
        mon_en = 1;

        // Directed corners
        run_cmd(0, 3'b001, 7, 8'hA5);   // single tx, fastest clock
        run_cmd(2, 3'b000, 7, 8'h3C);   // single rx, MOSI still driven
        run_cmd(1, 3'b100, 3, 8'h00);   // dual rx, full byte
        run_cmd(0, 3'b110, 1, 8'h00);   // quad rx, full byte
        run_cmd(3, 3'b011, 7, 8'h96);   // code 01 treated as single
        run_cmd(0, 3'b000, 2, 8'h00);   // short dummy burst
        run_cmd(1, 3'b111, 7, 8'h81);   // quad tx beyond one byte
        run_cmd(1, 3'b101, 3, 8'hD2);   // dual tx
        run_cmd(9, 3'b010, 0, 8'h80);   // single pulse, slow clock

        // R8: second command waiting for the final falling edge
        start_cmd(1, 3'b111, 1, 8'hC3);
        while (rise_cnt < 2) step();
        check(tx_acc == 32'hC3, "R2 quad tx before back-to-back", tx_acc, 32'hC3);
        cmd_div = 8'd1; cmd_mode = 3'b101; cmd_clks = 3'd3; cmd_txd = 8'h5A; cmd_valid = 1'b1;
        while (!cmd_ready) step();
        check(bus_idle == 1'b0, "R8 still busy at handover", bus_idle, 0);
        check((cyc + 1) - last_tog == 2, "R8 handover at final fall", (cyc + 1) - last_tog, 2);
        start_cmd(1, 3'b101, 3, 8'h5A);
        finish_cmd();

        // R9: reset in the middle of a long command
        start_cmd(3, 3'b001, 7, 8'hFF);
        repeat (11) step();
        mon_en = 0;
        rst_n = 1'b0;
        step();
        check_reset_state("R9 reset mid-command");
        rst_n = 1'b1;
        step();
        mon_en = 1;

        // Seeded random commands
        for (int n = 0; n < 60; n++) begin
            run_cmd($urandom_range(0, 3), 3'($urandom), $urandom_range(0, 7), 8'($urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule